// File: doc/BRIEF.md
# DMA Channel Enable and Structure-Select Control Bank

This block keeps two per-channel state vectors for a 14-channel DMA controller. One says whether each channel is enabled. The other says whether each channel is working from its primary or its alternate control structure. Software changes each vector through a pair of addresses: writing a one to a bit at the "set" address forces that bit high, and writing a one at the "clear" address forces it low. Zero bits in the write data leave the matching channel alone, so software never has to read, modify and write back.

The transfer engine also changes the bits on its own. A per-channel completion pulse disables the channel. A per-channel swap pulse flips the channel's structure selection, as ping-pong and scatter-gather operation need. When an engine pulse and a software write hit the same bit in the same cycle, the engine pulse decides the result. Both vectors drive the engine continuously. Reads return data combinationally in the cycle that `bus_rd_en` is high. Writes take effect at the next rising clock edge.

Top module: `dma_chan_ctl_bank`

## Requirements
- R1: After reset, every enable bit and every structure-select bit is 0, and both output vectors read 0.
- R2: A write to offset 0x28 sets each enable bit whose data bit (bit C for channel C) is 1. Data bits that are 0 leave the matching channel unchanged.
- R3: A write to offset 0x2C clears each enable bit whose data bit is 1. Data bits that are 0 leave the matching channel unchanged.
- R4: A read at offset 0x28 or at offset 0x2C returns the enable vector in bits 13:0.
- R5: A pulse on `eng_done[C]` clears enable bit C at the next clock edge.
- R6: A write to offset 0x30 sets each structure-select bit whose data bit is 1. A read at offset 0x30 returns the structure-select vector in bits 13:0, where 1 means the alternate structure and 0 means the primary structure.
- R7: A write to offset 0x34 clears each structure-select bit whose data bit is 1. A read at offset 0x34 returns 0.
- R8: A pulse on `eng_swap[C]` inverts structure-select bit C at the next clock edge.
- R9: When an engine pulse and a software write reach the same bit in the same cycle, the engine pulse decides that bit:
  - a completion pulse leaves the enable bit at 0;
  - a swap pulse inverts the bit's old value.
- R10: Read data bits 31:14 are always 0, and write data bits 31:14 are ignored.
- R11: A write to any address outside 0x28, 0x2C, 0x30 and 0x34 changes no state. A read at any such address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while bus_rd_en is high |
| eng_done | input | 14 | Per-channel cycle-complete pulses |
| eng_swap | input | 14 | Per-channel structure-swap pulses |
| chan_enable | output | 14 | Current enable vector |
| chan_alt_sel | output | 14 | Current structure-select vector (1 = alternate) |

## Verification
The assertions assume that `bus_wr_en` and `bus_rd_en` are never high in the same cycle. They also assume that the engine pulses are one-cycle events sampled at the rising edge. They place no limit on how many channels pulse together, and no limit on how a pulse lines up with a software write. The stimulus keeps to these rules because it issues each bus access on its own at a falling edge. It draws the engine pulses as sparse random masks, and it deliberately overlaps them with writes to the same bits so that the hardware-wins precedence gets exercised.

// File: rtl/dma_bank_pkg.sv
package dma_bank_pkg;

  localparam logic [7:0] OFS_EN_SET  = 8'h28;
  localparam logic [7:0] OFS_EN_CLR  = 8'h2C;
  localparam logic [7:0] OFS_ALT_SET = 8'h30;
  localparam logic [7:0] OFS_ALT_CLR = 8'h34;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN_SET,
    SEL_EN_CLR,
    SEL_ALT_SET,
    SEL_ALT_CLR
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [7:0] ofs);
    case (ofs)
      OFS_EN_SET:  return SEL_EN_SET;
      OFS_EN_CLR:  return SEL_EN_CLR;
      OFS_ALT_SET: return SEL_ALT_SET;
      OFS_ALT_CLR: return SEL_ALT_CLR;
      default:     return SEL_NONE;
    endcase
  endfunction

  // Enable: a completion pulse dominates any software request.
  function automatic logic enable_next(input logic cur, input logic sw_set,
                                       input logic sw_clr, input logic hw_done);
    if (hw_done) return 1'b0;
    if (sw_set)  return 1'b1;
    if (sw_clr)  return 1'b0;
    return cur;
  endfunction

  // Structure select: a swap pulse inverts the old value, whatever software writes.
  function automatic logic alt_next(input logic cur, input logic sw_set,
                                    input logic sw_clr, input logic hw_swap);
    if (hw_swap) return ~cur;
    if (sw_set)  return 1'b1;
    if (sw_clr)  return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/dma_bank_decode.sv
module dma_bank_decode
  import dma_bank_pkg::*;
#(
  parameter int NUM_CH = 14,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wdata,
  output reg_sel_e          sel,
  output logic [NUM_CH-1:0] wr_en_set,
  output logic [NUM_CH-1:0] wr_en_clr,
  output logic [NUM_CH-1:0] wr_alt_set,
  output logic [NUM_CH-1:0] wr_alt_clr
);
  logic [NUM_CH-1:0] data_ch;

  assign sel     = decode_offset(8'(bus_addr));
  assign data_ch = bus_wdata[NUM_CH-1:0];

  always_comb begin
    wr_en_set  = '0;
    wr_en_clr  = '0;
    wr_alt_set = '0;
    wr_alt_clr = '0;
    if (bus_wr_en) begin
      case (sel)
        SEL_EN_SET:  wr_en_set  = data_ch;
        SEL_EN_CLR:  wr_en_clr  = data_ch;
        SEL_ALT_SET: wr_alt_set = data_ch;
        SEL_ALT_CLR: wr_alt_clr = data_ch;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma_bank_state.sv
module dma_bank_state
  import dma_bank_pkg::*;
#(
  parameter int NUM_CH = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] wr_en_set,
  input  logic [NUM_CH-1:0] wr_en_clr,
  input  logic [NUM_CH-1:0] wr_alt_set,
  input  logic [NUM_CH-1:0] wr_alt_clr,
  input  logic [NUM_CH-1:0] eng_done,
  input  logic [NUM_CH-1:0] eng_swap,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] alt_q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic en_d, alt_d;
    assign en_d  = enable_next(en_q[c], wr_en_set[c], wr_en_clr[c], eng_done[c]);
    assign alt_d = alt_next(alt_q[c], wr_alt_set[c], wr_alt_clr[c], eng_swap[c]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[c]  <= 1'b0;
        alt_q[c] <= 1'b0;
      end else begin
        en_q[c]  <= en_d;
        alt_q[c] <= alt_d;
      end
    end

    assert_set_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_set[c] && !eng_done[c]) |=> en_q[c]);
    assert_clr_disables_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_clr[c] |=> !en_q[c]);
    assert_done_wins_R5_R9: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done[c] |=> !en_q[c]);
    assert_alt_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_alt_set[c] && !eng_swap[c]) |=> alt_q[c]);
    assert_alt_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_alt_clr[c] && !eng_swap[c]) |=> !alt_q[c]);
    assert_swap_inverts_R8_R9: assert property (@(posedge clk) disable iff (!rst_n)
      eng_swap[c] |=> (alt_q[c] != $past(alt_q[c])));
    assert_en_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_set[c] || wr_en_clr[c] || eng_done[c]) |=> $stable(en_q[c]));
    assert_alt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_alt_set[c] || wr_alt_clr[c] || eng_swap[c]) |=> $stable(alt_q[c]));
  end
endmodule

// File: rtl/dma_bank_readmux.sv
module dma_bank_readmux
  import dma_bank_pkg::*;
#(
  parameter int NUM_CH = 14,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd_en,
  input  reg_sel_e          sel,
  input  logic [NUM_CH-1:0] en_q,
  input  logic [NUM_CH-1:0] alt_q,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int PAD_W = DATA_W - NUM_CH;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd_en) begin
      case (sel)
        SEL_EN_SET, SEL_EN_CLR: bus_rdata = {{PAD_W{1'b0}}, en_q};
        SEL_ALT_SET:            bus_rdata = {{PAD_W{1'b0}}, alt_q};
        default:                bus_rdata = '0;
      endcase
    end
  end

  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NUM_CH] == '0);
  assert_altclr_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && sel == SEL_ALT_CLR) |-> bus_rdata == '0);
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> bus_rdata == '0);
  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |-> bus_rdata == '0);
endmodule

// File: rtl/dma_chan_ctl_bank.sv
module dma_chan_ctl_bank
  import dma_bank_pkg::*;
#(
  parameter int NUM_CH = 14,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] eng_done,
  input  logic [NUM_CH-1:0] eng_swap,
  output logic [NUM_CH-1:0] chan_enable,
  output logic [NUM_CH-1:0] chan_alt_sel
);
  reg_sel_e          sel;
  logic [NUM_CH-1:0] wr_en_set, wr_en_clr, wr_alt_set, wr_alt_clr;
  logic [NUM_CH-1:0] en_q, alt_q;

  dma_bank_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .sel       (sel),
    .wr_en_set (wr_en_set),
    .wr_en_clr (wr_en_clr),
    .wr_alt_set(wr_alt_set),
    .wr_alt_clr(wr_alt_clr)
  );

  dma_bank_state #(.NUM_CH(NUM_CH)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_set (wr_en_set),
    .wr_en_clr (wr_en_clr),
    .wr_alt_set(wr_alt_set),
    .wr_alt_clr(wr_alt_clr),
    .eng_done  (eng_done),
    .eng_swap  (eng_swap),
    .en_q      (en_q),
    .alt_q     (alt_q)
  );

  dma_bank_readmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_readmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd_en(bus_rd_en),
    .sel      (sel),
    .en_q     (en_q),
    .alt_q    (alt_q),
    .bus_rdata(bus_rdata)
  );

  assign chan_enable  = en_q;
  assign chan_alt_sel = alt_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (chan_enable == '0 && chan_alt_sel == '0));
endmodule

// File: tb/dma_chan_ctl_bank_tb.sv
module dma_chan_ctl_bank_tb_top;
  localparam int NCH = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd_en = 1'b0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] eng_done = '0;
  logic [NCH-1:0] eng_swap = '0;
  logic [NCH-1:0] chan_enable, chan_alt_sel;

  int checks = 0;
  int failures = 0;
  logic [NCH-1:0] m_en = '0;
  logic [NCH-1:0] m_alt = '0;

  always #4 clk = ~clk;

  dma_chan_ctl_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .eng_done(eng_done), .eng_swap(eng_swap),
    .chan_enable(chan_enable), .chan_alt_sel(chan_alt_sel)
  );

  // Reference model, written as mask algebra rather than a priority chain.
  function automatic logic [NCH-1:0] ref_en(input logic [NCH-1:0] cur, input logic [7:0] a,
                                            input logic w, input logic [31:0] d,
                                            input logic [NCH-1:0] dn);
    logic [NCH-1:0] s = (w && a == 8'h28) ? d[NCH-1:0] : '0;
    logic [NCH-1:0] c = (w && a == 8'h2C) ? d[NCH-1:0] : '0;
    return ((cur | s) & ~c) & ~dn;
  endfunction

  function automatic logic [NCH-1:0] ref_alt(input logic [NCH-1:0] cur, input logic [7:0] a,
                                             input logic w, input logic [31:0] d,
                                             input logic [NCH-1:0] sw);
    logic [NCH-1:0] s = (w && a == 8'h30) ? d[NCH-1:0] : '0;
    logic [NCH-1:0] c = (w && a == 8'h34) ? d[NCH-1:0] : '0;
    return (sw & ~cur) | (~sw & ((cur | s) & ~c));
  endfunction

  function automatic logic [31:0] ref_rd(input logic [7:0] a);
    case (a)
      8'h28, 8'h2C: return {18'd0, m_en};
      8'h30:        return {18'd0, m_alt};
      default:      return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] a, input logic w, input logic [31:0] d,
                     input logic [NCH-1:0] dn, input logic [NCH-1:0] sw, input string req);
    @(negedge clk);
    bus_addr = a; bus_wr_en = w; bus_wdata = d; eng_done = dn; eng_swap = sw;
    @(posedge clk);
    m_en  = ref_en(m_en, a, w, d, dn);
    m_alt = ref_alt(m_alt, a, w, d, sw);
    @(negedge clk);
    bus_wr_en = 1'b0; eng_done = '0; eng_swap = '0;
    check({req, " enable"}, 32'(chan_enable), 32'(m_en));
    check({req, " alt"}, 32'(chan_alt_sel), 32'(m_alt));
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    #1;
    check(req, bus_rdata, ref_rd(a));
    bus_rd_en = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 enable", 32'(chan_enable), 32'd0);
    check("R1 alt", 32'(chan_alt_sel), 32'd0);
    rst_n = 1'b1;
    rd(8'h28, "R1 read en");
    // R2 / R3 / R4
    cyc(8'h28, 1'b1, 32'h0000_2A5F, '0, '0, "R2 set");
    cyc(8'h28, 1'b1, 32'h0000_0000, '0, '0, "R2 zero-write");
    rd(8'h28, "R4 read set addr");
    cyc(8'h2C, 1'b1, 32'h0000_000F, '0, '0, "R3 clear");
    rd(8'h2C, "R4 read clr addr");
    // R5
    cyc(8'h00, 1'b0, 32'd0, 14'h0050, '0, "R5 done");
    // R6 / R7
    cyc(8'h30, 1'b1, 32'h0000_3C03, '0, '0, "R6 alt set");
    rd(8'h30, "R6 read alt");
    cyc(8'h34, 1'b1, 32'h0000_0C01, '0, '0, "R7 alt clr");
    rd(8'h34, "R7 read alt clr zero");
    // R8
    cyc(8'h00, 1'b0, 32'd0, '0, 14'h0003, "R8 swap");
    // R9 conflicts: set vs done, alt-set vs swap on a 1, alt-clr vs swap on a 0
    cyc(8'h28, 1'b1, 32'h0000_0008, 14'h0008, '0, "R9 set vs done");
    cyc(8'h30, 1'b1, 32'h0000_2000, '0, 14'h2000, "R9 altset vs swap");
    cyc(8'h34, 1'b1, 32'h0000_0004, '0, 14'h0004, "R9 altclr vs swap");
    // R10 / R11
    cyc(8'h28, 1'b1, 32'hFFFF_0000, '0, '0, "R10 upper write ignored");
    rd(8'h28, "R10 upper read zero");
    cyc(8'h3C, 1'b1, 32'hFFFF_FFFF, '0, '0, "R11 unmapped write");
    cyc(8'h29, 1'b1, 32'hFFFF_FFFF, '0, '0, "R11 misaligned write");
    rd(8'h3C, "R11 unmapped read");
    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      int k = $urandom_range(0, 5);
      case (k)
        0: a = 8'h28; 1: a = 8'h2C; 2: a = 8'h30;
        3: a = 8'h34; 4: a = 8'h3C; default: a = 8'h00;
      endcase
      cyc(a, 1'($urandom_range(0, 3) != 0), $urandom,
          14'($urandom & $urandom & $urandom), 14'($urandom & $urandom & $urandom),
          "R9 random");
      rd(a, "R4 random read");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule